// File: doc/BRIEF.md
# Sleep-State Wake-Up Qualifier

This block watches two wake sources while a bus transceiver sleeps: the sampled level of a single-wire bus (dominant or recessive) and an active-low local wake switch. Each source has its own debounce filter, which counts microsecond ticks supplied from outside. A bus wake counts only when a dominant phase that began with a falling edge lasts at least the bus filter time and then returns to recessive. A local wake counts when the switch, after being high long enough to re-arm, goes low and stays low for the local filter time.

A qualified wake raises a held request flag, which the surrounding logic uses to pull the receive output low. A source flag, also held, selects a strong pull-down on the transmit pin for a local wake and a weak one for a bus wake. A one-cycle mode-change pulse asks the mode controller to leave sleep for the fail-safe state. Driving enable high clears both flags in the same cycle.

Top module: `lin_wake_detect`

## Requirements
- R1: While reset is held and after it is released, wake_req_o, wake_local_o and mode_req_o are 0.
- R2: In sleep, when bus_dom_i rises from 0 to 1, stays 1 for at least BUS_FILT_US ticks after that edge and then returns to 0, wake_req_o goes to 1 with wake_local_o = 0 (bus source), and mode_req_o is 1 for exactly one cycle.
- R3: A dominant bus phase that ends before BUS_FILT_US ticks is discarded and its count restarts, so two short phases never add up to a wake.
- R4: A bus dominant phase that has already lasted the filter time gives no wake until bus_dom_i returns to 0.
- R5: In sleep, when wake_n_i falls from an armed state and stays 0 for at least LOC_FILT_US ticks, wake_req_o goes to 1 with wake_local_o = 1 (local source) and one mode_req_o pulse.
- R6: A local low pulse shorter than LOC_FILT_US ticks is discarded.
- R7: The local filter is armed only after wake_n_i has been 1 for more than LOC_REARM_US ticks. A switch that stays low, including one already low when sleep is entered, never causes a wake.
- R8: While en_i is 1, wake_req_o and wake_local_o read 0 in the same cycle, the held flags are cleared, and no new wake is accepted.
- R9: With sleep_i = 0, neither source can produce a wake.
- R10: When both sources qualify in the same cycle, the local source wins (wake_local_o = 1).
- R11: Once a wake is held, a later qualifying event from either source leaves wake_local_o unchanged until enable clears the flags.
- R12: Filter counts advance only in cycles where tick_us is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| sleep_i | input | 1 | High while the transceiver is in sleep |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| wake_n_i | input | 1 | Local wake switch, 0 = pressed |
| en_i | input | 1 | Enable; high clears the wake flags |
| wake_req_o | output | 1 | Held wake request |
| wake_local_o | output | 1 | Source flag, 1 = local switch, 0 = bus |
| mode_req_o | output | 1 | One-cycle pulse asking to leave sleep |

## Verification
A vector table sends bus dominant phases and local low pulses of several lengths. Lengths sit exactly at, one below and well above each filter time, which separates an off-by-one filter from a correct one. Directed patterns then cover the following: two back-to-back short bus phases, which catch a count that is not cleared; a held dominant level, which shows that the rising edge is needed; a re-arm high time one tick too short, and a switch already low when sleep starts; bus and switch qualifying in the same cycle, which shows the priority; and stimulus sent with sleep low, with enable high, or with ticks stopped.

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
  parameter int BUS_FILT_US  = 90,
  parameter int LOC_FILT_US  = 35,
  parameter int LOC_REARM_US = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic sleep_i,
  input  logic bus_dom_i,
  input  logic wake_n_i,
  input  logic en_i,
  output logic wake_req_o,
  output logic wake_local_o,
  output logic mode_req_o
);
  localparam int BW = $clog2(BUS_FILT_US + 1);
  localparam int LW = $clog2(LOC_FILT_US + 1);
  localparam int RW = $clog2(LOC_REARM_US + 2);
  localparam logic [BW-1:0] B_LAST = BW'(BUS_FILT_US - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LOC_FILT_US - 1);
  localparam logic [RW-1:0] R_LIM  = RW'(LOC_REARM_US);

  logic          bus_q, b_run, b_arm;
  logic [BW-1:0] b_cnt;
  logic [RW-1:0] hi_cnt;
  logic          l_run;
  logic [LW-1:0] l_cnt;
  logic          req_q, src_q, mode_q;

  logic b_fall, b_hit, l_armed, l_start, l_hit, set_req;
  assign b_fall  = sleep_i & bus_dom_i & ~bus_q;
  assign b_hit   = sleep_i & b_run & b_arm & ~bus_dom_i;
  assign l_armed = hi_cnt > R_LIM;
  assign l_start = sleep_i & ~wake_n_i & l_armed & ~l_run;
  assign l_hit   = sleep_i & l_run & ~wake_n_i & tick_us & (l_cnt == L_LAST);
  assign set_req = ~req_q & ~en_i & (b_hit | l_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= 1'b0;
      b_run <= 1'b0;
      b_arm <= 1'b0;
      b_cnt <= '0;
    end else begin
      bus_q <= bus_dom_i;
      if (!sleep_i) begin
        b_run <= 1'b0;
        b_arm <= 1'b0;
        b_cnt <= '0;
      end else if (b_fall) begin
        b_run <= 1'b1;
        b_arm <= 1'b0;
        b_cnt <= '0;
      end else if (b_run) begin
        if (!bus_dom_i) begin
          b_run <= 1'b0;
          b_arm <= 1'b0;
          b_cnt <= '0;
        end else if (tick_us && !b_arm) begin
          if (b_cnt == B_LAST) b_arm <= 1'b1;
          else                 b_cnt <= b_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      l_run  <= 1'b0;
      l_cnt  <= '0;
    end else begin
      if (!wake_n_i)               hi_cnt <= '0;
      else if (tick_us && !l_armed) hi_cnt <= hi_cnt + 1'b1;
      if (!sleep_i) begin
        l_run <= 1'b0;
        l_cnt <= '0;
      end else if (l_start) begin
        l_run <= 1'b1;
        l_cnt <= '0;
      end else if (l_run) begin
        if (wake_n_i || l_hit) begin
          l_run <= 1'b0;
          l_cnt <= '0;
        end else if (tick_us) begin
          l_cnt <= l_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      src_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= set_req;
      if (en_i) begin
        req_q <= 1'b0;
        src_q <= 1'b0;
      end else if (set_req) begin
        req_q <= 1'b1;
        src_q <= l_hit;
      end
    end
  end

  assign wake_req_o   = req_q & ~en_i;
  assign wake_local_o = src_q & ~en_i;
  assign mode_req_o   = mode_q;
endmodule

// File: rtl/lin_wake_detect_chk.sv
module lin_wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_i,
  input logic bus_dom_i,
  input logic wake_n_i,
  input logic en_i,
  input logic wake_req_o,
  input logic wake_local_o,
  input logic mode_req_o
);
  p_mode_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_o |=> !mode_req_o);
  p_mode_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_o |-> (wake_req_o || en_i));
  p_bus_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_req_o) && !wake_local_o) |-> !$past(bus_dom_i));
  p_local_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_req_o) && wake_local_o) |-> !$past(wake_n_i));
  p_en_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (!wake_req_o && !wake_local_o));
  p_only_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> $past(sleep_i));
  p_src_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && $past(wake_req_o)) |-> $stable(wake_local_o));
  p_src_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_local_o |-> wake_req_o);
endmodule

bind lin_wake_detect lin_wake_detect_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bus_dom_i(bus_dom_i),
  .wake_n_i(wake_n_i), .en_i(en_i), .wake_req_o(wake_req_o),
  .wake_local_o(wake_local_o), .mode_req_o(mode_req_o)
);

// File: tb/test_lin_wake_detect.sv
module test_lin_wake_detect;
  localparam int CLK_P = 10;
  localparam int BF = 90;
  localparam int LF = 35;
  localparam int RA = 6;
  localparam int NV = 8;
  // [15] 1 = local pulse, 0 = bus dominant phase; [14] wake expected; [11:0] length in ticks
  localparam logic [15:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 2'b00, 12'(BF + 1)},
    {1'b0, 1'b0, 2'b00, 12'(BF)},
    {1'b0, 1'b0, 2'b00, 12'(3)},
    {1'b0, 1'b1, 2'b00, 12'(BF + 10)},
    {1'b1, 1'b1, 2'b00, 12'(LF + 1)},
    {1'b1, 1'b0, 2'b00, 12'(LF)},
    {1'b1, 1'b0, 2'b00, 12'(1)},
    {1'b1, 1'b1, 2'b00, 12'(2 * LF)}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b1, sleep_i = 1'b0;
  logic bus_dom_i = 1'b0, wake_n_i = 1'b1, en_i = 1'b0;
  logic wake_req_o, wake_local_o, mode_req_o;
  int total = 0, bad = 0, mode_cnt = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;
  always @(negedge clk) if (mode_req_o) mode_cnt++;

  lin_wake_detect #(.BUS_FILT_US(BF), .LOC_FILT_US(LF), .LOC_REARM_US(RA)) i_lin_wake_detect (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .sleep_i(sleep_i),
    .bus_dom_i(bus_dom_i), .wake_n_i(wake_n_i), .en_i(en_i),
    .wake_req_o(wake_req_o), .wake_local_o(wake_local_o), .mode_req_o(mode_req_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    wake_n_i = 1'b1;
    idle(RA + 3);
  endtask

  task automatic local_pulse(input int len);
    rearm();
    wake_n_i = 1'b0;
    idle(len);
    wake_n_i = 1'b1;
    idle(4);
  endtask

  task automatic bus_pulse(input int len);
    bus_dom_i = 1'b0;
    idle(3);
    bus_dom_i = 1'b1;
    idle(len);
    bus_dom_i = 1'b0;
    idle(4);
  endtask

  task automatic clear_flags();
    en_i = 1'b1;
    idle(2);
    en_i = 1'b0;
    idle(1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 req in reset", wake_req_o, 0);
    chk("R1 mode in reset", mode_req_o, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 req after reset", wake_req_o, 0);
    chk("R1 src after reset", wake_local_o, 0);
    sleep_i = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int m0;
      m0 = mode_cnt;
      if (VEC[i][15]) local_pulse(int'(VEC[i][11:0]));
      else            bus_pulse(int'(VEC[i][11:0]));
      chk(VEC[i][15] ? "R5/R6 local wake" : "R2/R3 bus wake", wake_req_o, int'(VEC[i][14]));
      if (VEC[i][14]) begin
        chk(VEC[i][15] ? "R5 local source" : "R2 bus source", wake_local_o, int'(VEC[i][15]));
        chk("R2 single mode pulse", mode_cnt - m0, 1);
      end
      clear_flags();
    end

    // R3: two short dominant phases whose sum exceeds the filter time
    bus_dom_i = 1'b1; idle(BF - 5);
    bus_dom_i = 1'b0; idle(2);
    bus_dom_i = 1'b1; idle(BF - 5);
    bus_dom_i = 1'b0; idle(4);
    chk("R3 no accumulation", wake_req_o, 0);

    // R4: held dominant does not wake until release
    bus_dom_i = 1'b1; idle(BF + 20);
    chk("R4 held dominant", wake_req_o, 0);
    bus_dom_i = 1'b0; idle(3);
    chk("R4 wake on release", wake_req_o, 1);

    // R8: enable masks flags in the same cycle
    @(negedge clk); en_i = 1'b1; #1;
    chk("R8 immediate clear", wake_req_o, 0);
    idle(1);
    local_pulse(LF + 5);
    chk("R8 blocked while enabled", wake_req_o, 0);
    en_i = 1'b0;
    idle(2);
    chk("R8 flag stays cleared", wake_req_o, 0);

    // R7: high phase one tick too short, then switch low already at sleep entry
    wake_n_i = 1'b1; idle(20);
    wake_n_i = 1'b0; idle(1);
    wake_n_i = 1'b1; idle(RA);
    wake_n_i = 1'b0; idle(LF + 10);
    chk("R7 re-arm too short", wake_req_o, 0);
    sleep_i = 1'b0; idle(3);
    sleep_i = 1'b1; idle(LF * 3);
    chk("R7 continuous low", wake_req_o, 0);
    wake_n_i = 1'b1; idle(RA + 2);
    wake_n_i = 1'b0; idle(LF + 3);
    chk("R7 wake after re-arm", wake_req_o, 1);
    wake_n_i = 1'b1;
    clear_flags();

    // R9: no wake out of sleep
    sleep_i = 1'b0;
    local_pulse(LF + 10);
    bus_pulse(BF + 10);
    chk("R9 awake ignores sources", wake_req_o, 0);
    sleep_i = 1'b1;
    idle(2);

    // R10: both sources qualify on the same edge
    rearm();
    bus_dom_i = 1'b1; idle(BF + 5);
    wake_n_i = 1'b0;
    idle(LF);
    bus_dom_i = 1'b0;
    idle(3);
    chk("R10 wake raised", wake_req_o, 1);
    chk("R10 local wins", wake_local_o, 1);
    wake_n_i = 1'b1;
    clear_flags();

    // R11: first source kept
    bus_pulse(BF + 5);
    local_pulse(LF + 5);
    chk("R11 req held", wake_req_o, 1);
    chk("R11 source kept", wake_local_o, 0);
    clear_flags();

    // R12: no ticks, no progress
    rearm();
    tick_us = 1'b0;
    wake_n_i = 1'b0; idle(LF * 3);
    chk("R12 no tick no wake", wake_req_o, 0);
    tick_us = 1'b1; idle(LF + 3);
    chk("R12 counts resume with tick", wake_req_o, 1);
    wake_n_i = 1'b1;
    clear_flags();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule